// File: doc/BRIEF.md
# Four-Channel E1 Byte Interleaver

This block merges four 2.048 Mbit/s E1 serial streams, already aligned to one another at frame level, into one 8.192 Mbit/s serial stream. Each output bit period is marked by a single-cycle `bit_en` strobe on the system clock. Every fourth strobe carries one input bit per channel. Each input byte is collected in a per-channel shift register. It then moves into a holding register and is sent out during the following timeslot. Within each timeslot the four channels go out in turn, lowest channel first, most significant bit first.

Alongside the data the block drives a frame sync output. A 2-bit mode input selects where the pulse sits: on the first bit of the frame only, straddling the boundary by one bit on each side, or straddling it by two bits on each side. A polarity input inverts the pulse in the two straddling modes. A fourth mode code keeps the line idle. The mode and polarity are taken in just before each frame boundary, so a pulse is never cut short.

The output frame is 1024 bits long: 32 timeslots, each holding 4 channels of 8 bits. It trails the input frame by exactly one timeslot, which is 32 strobes.

Top module: `e1_quad_interleaver`

## Requirements
- R1: After reset `ser_out` is 1 and `sync_out` is 0. The active mode is idle (code 00) until the first configuration capture.
- R2: The design acts on `ch_in` and `fs_in` only in clock cycles where `bit_en` is 1. Call the strobe on which `fs_in` is high strobe 0. Input bits are sampled only on strobes whose index since strobe 0 is a multiple of 4. Values on the other three strobes have no effect. Each input byte arrives MSB first, and `ch_in[i]` is channel i.
- R3: Output timeslot k carries the byte that each channel delivered in input timeslot k. The channels appear in the order 0, 1, 2, 3, each byte MSB first. Output frame position p therefore holds channel (p mod 32)/8, bit 7-(p mod 8), of timeslot p/32.
- R4: Output position p is presented after the strobe numbered (32+p) mod 1024 since strobe 0 of the input frame. Output position 0 follows strobe 32, one timeslot after the input frame starts.
- R5: In mode 00, `ser_out` is 1 at every position and `sync_out` stays 0.
- R6: In mode 01, `sync_out` is 1 only at output position 0. It is active high whatever the value of `sync_inv`.
- R7: In mode 10, the sync pulse covers output positions 1022, 1023, 0 and 1.
- R8: In mode 11, the sync pulse covers output positions 1023 and 0.
- R9: In modes 10 and 11, `sync_inv`=1 makes the pulse active low (idle level 1). `sync_inv`=0 makes it active high.
- R10: `mode_sel` and `sync_inv` are captured only on the strobe that presents output position 1021. They take effect from position 1022, so they govern the whole of the next frame's pulse.
- R11: `ser_out` and `sync_out` change only on clock edges where `bit_en` is 1.
- R12: Raising `fs_in` on a strobe in mid-frame restarts the frame count there. From then on, outputs follow R3, R4 and R10 relative to the new strobe 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per output bit period |
| fs_in | input | 1 | Input frame start, qualified by `bit_en` |
| ch_in | input | 4 | Serial input bit for each channel |
| mode_sel | input | 2 | Sync and data mode (00 idle, 01 first bit, 10 four-bit straddle, 11 two-bit straddle) |
| sync_inv | input | 1 | Active-low sync in modes 10 and 11 |
| ser_out | output | 1 | Interleaved serial output |
| sync_out | output | 1 | Output frame sync |

## Verification
Two things happen on the same strobe at the last bit of every output timeslot. The serializer sends channel 3's least significant bit out of the holding registers, and on that very edge the holding registers are reloaded with the next timeslot's bytes. Fresh random bytes in every slot of every frame make a premature or late reload show up as wrong bits around timeslot edges. The scoreboard compares each output bit against the byte the bench itself placed on the inputs. A second coincidence is tested as well. The mode pins are changed in mid-frame and toggled between strobes, and the configuration capture at position 1021 falls on the same edge as ordinary serialization. The bench predicts which mode governs each sync bit from the pin value present at that one strobe.

// File: rtl/ebi_pkg.sv
`timescale 1ns/1ps
package ebi_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'b00,
      MODE_FIRST  = 2'b01,
      MODE_WIDE   = 2'b10,
      MODE_NARROW = 2'b11
   } sync_mode_e;

   typedef struct packed {
      sync_mode_e mode;
      logic       inv;
   } frame_cfg_t;

endpackage

// File: rtl/ebi_timebase.sv
`timescale 1ns/1ps
module ebi_timebase #(
   parameter  int NCH      = 4,
   parameter  int SLOTS    = 32,
   parameter  int BYTE_W   = 8,
   localparam int NCH_L    = $clog2(NCH),
   localparam int W_L      = $clog2(BYTE_W),
   localparam int SLOT_LEN = NCH * BYTE_W,
   localparam int SLOT_LW  = $clog2(SLOT_LEN),
   localparam int FRAME    = SLOTS * SLOT_LEN,
   localparam int FW       = $clog2(FRAME)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             fs_in,
   output logic             sample_en,
   output logic             xfer_en,
   output logic [FW-1:0]    out_pos,
   output logic [NCH_L-1:0] out_ch,
   output logic [W_L-1:0]   out_bit
);

   logic [FW-1:0] cnt_q;
   logic [FW-1:0] icnt;

   // strobe position inside the input frame; a qualified frame start forces zero
   always_comb begin
      icnt = (bit_en && fs_in) ? '0 : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bit_en) begin
         cnt_q <= icnt + FW'(1);
      end
   end

   // output frame trails the input frame by one timeslot
   always_comb begin
      out_pos   = icnt - FW'(SLOT_LEN);
      out_ch    = out_pos[SLOT_LW-1:W_L];
      out_bit   = out_pos[W_L-1:0];
      sample_en = bit_en && (icnt[NCH_L-1:0] == '0);
      xfer_en   = bit_en && (&icnt[SLOT_LW-1:0]);
   end

endmodule

// File: rtl/ebi_lane_buf.sv
`timescale 1ns/1ps
module ebi_lane_buf #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              xfer_en,
   input  logic              din,
   output logic [BYTE_W-1:0] hold_q
);

   logic [BYTE_W-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '1;
      end else if (sample_en) begin
         shift_q <= {shift_q[BYTE_W-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '1;
      end else if (xfer_en) begin
         hold_q <= shift_q;
      end
   end

   AST_HOLD_ONLY_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_en |=> $stable(hold_q)); // R3

endmodule

// File: rtl/ebi_sync_gen.sv
`timescale 1ns/1ps
module ebi_sync_gen
   import ebi_pkg::*;
#(
   parameter  int FRAME = 1024,
   localparam int FW    = $clog2(FRAME)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic [1:0]    mode_in,
   input  logic          inv_in,
   input  logic [FW-1:0] out_pos,
   output logic          idle,
   output logic          sync_out
);

   localparam logic [FW-1:0] POS_CAPTURE = FW'(FRAME - 3);
   localparam logic [FW-1:0] POS_LAST2   = FW'(FRAME - 2);
   localparam logic [FW-1:0] POS_LAST    = FW'(FRAME - 1);
   localparam logic [FW-1:0] POS_SECOND  = FW'(1);

   frame_cfg_t cfg_q;
   logic       at_first, at_second, at_last, at_last2;
   logic       active, level, straddle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{mode: MODE_IDLE, inv: 1'b0};
      end else if (bit_en && out_pos == POS_CAPTURE) begin
         cfg_q <= '{mode: sync_mode_e'(mode_in), inv: inv_in};
      end
   end

   always_comb begin
      at_first  = (out_pos == '0);
      at_second = (out_pos == POS_SECOND);
      at_last   = (out_pos == POS_LAST);
      at_last2  = (out_pos == POS_LAST2);
      straddle  = (cfg_q.mode == MODE_WIDE) || (cfg_q.mode == MODE_NARROW);
      unique case (cfg_q.mode)
         MODE_IDLE:  active = 1'b0;
         MODE_FIRST: active = at_first;
         MODE_WIDE:  active = at_last2 | at_last | at_first | at_second;
         default:    active = at_last | at_first;
      endcase
      level = (straddle && cfg_q.inv) ? ~active : active;
      idle  = (cfg_q.mode == MODE_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_out <= 1'b0;
      end else if (bit_en) begin
         sync_out <= level;
      end
   end

   AST_IDLE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && cfg_q.mode == MODE_IDLE |=> !sync_out); // R5
   AST_FIRST_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && cfg_q.mode == MODE_FIRST && out_pos != '0 |=> !sync_out); // R6
   AST_FIRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && cfg_q.mode == MODE_FIRST && out_pos == '0 |=> sync_out); // R6
   AST_NARROW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && cfg_q.mode == MODE_NARROW && !cfg_q.inv && out_pos == POS_LAST |=> sync_out); // R8
   AST_CFG_ONLY_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_en && out_pos == POS_CAPTURE) |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/ebi_serializer.sv
`timescale 1ns/1ps
module ebi_serializer #(
   parameter  int NCH    = 4,
   parameter  int BYTE_W = 8,
   localparam int NCH_L  = $clog2(NCH),
   localparam int W_L    = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              idle,
   input  logic [BYTE_W-1:0] hold [NCH],
   input  logic [NCH_L-1:0]  sel_ch,
   input  logic [W_L-1:0]    sel_bit,
   output logic              ser_out
);

   logic [BYTE_W-1:0] cur_byte;
   logic              cur_bit;

   // position 0 in the byte is the MSB
   always_comb begin
      cur_byte = hold[sel_ch];
      cur_bit  = cur_byte[~sel_bit];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_out <= 1'b1;
      end else if (bit_en) begin
         ser_out <= idle ? 1'b1 : cur_bit;
      end
   end

   AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && idle |=> ser_out); // R5

endmodule

// File: rtl/e1_quad_interleaver.sv
`timescale 1ns/1ps
module e1_quad_interleaver #(
   parameter  int NCH    = 4,
   parameter  int SLOTS  = 32,
   parameter  int BYTE_W = 8,
   localparam int NCH_L  = $clog2(NCH),
   localparam int W_L    = $clog2(BYTE_W),
   localparam int FRAME  = SLOTS * NCH * BYTE_W,
   localparam int FW     = $clog2(FRAME)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_en,
   input  logic           fs_in,
   input  logic [NCH-1:0] ch_in,
   input  logic [1:0]     mode_sel,
   input  logic           sync_inv,
   output logic           ser_out,
   output logic           sync_out
);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_w
      $error("BYTE_W must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end

   logic              sample_en, xfer_en, idle;
   logic [FW-1:0]     out_pos;
   logic [NCH_L-1:0]  out_ch;
   logic [W_L-1:0]    out_bit;
   logic [BYTE_W-1:0] hold [NCH];

   ebi_timebase #(.NCH(NCH), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .fs_in     (fs_in),
      .sample_en (sample_en),
      .xfer_en   (xfer_en),
      .out_pos   (out_pos),
      .out_ch    (out_ch),
      .out_bit   (out_bit)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_lane
      ebi_lane_buf #(.BYTE_W(BYTE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample_en (sample_en),
         .xfer_en   (xfer_en),
         .din       (ch_in[g]),
         .hold_q    (hold[g])
      );
   end

   ebi_sync_gen #(.FRAME(FRAME)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .mode_in  (mode_sel),
      .inv_in   (sync_inv),
      .out_pos  (out_pos),
      .idle     (idle),
      .sync_out (sync_out)
   );

   ebi_serializer #(.NCH(NCH), .BYTE_W(BYTE_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .idle    (idle),
      .hold    (hold),
      .sel_ch  (out_ch),
      .sel_bit (out_bit),
      .ser_out (ser_out)
   );

   AST_QUIET_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(ser_out) && $stable(sync_out)); // R11

endmodule

// File: tb/e1_quad_interleaver_test.sv
`timescale 1ns/1ps
module e1_quad_interleaver_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       fs_in;
   logic [3:0] ch_in;
   logic [1:0] mode_sel;
   logic       sync_inv;
   logic       ser_out;
   logic       sync_out;

   always #10 clk = ~clk; // 50 MHz

   e1_quad_interleaver uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .fs_in    (fs_in),
      .ch_in    (ch_in),
      .mode_sel (mode_sel),
      .sync_inv (sync_inv),
      .ser_out  (ser_out),
      .sync_out (sync_out)
   );

   typedef struct {
      logic  ser;
      logic  sync;
      bit    ser_dc;
      string ser_tag;
      string sync_tag;
   } item_t;

   item_t      sbq[$];
   int         n_chk = 0;
   int         n_bad = 0;
   int         s = 0;
   int         dc_left = 0;
   int         eff_mode = 0;
   bit         eff_pol = 0;
   bit         boot = 1;
   bit         garbage = 0;
   bit         mon_on = 0;
   logic       took = 0;
   logic       last_ser, last_sync;
   logic [1:0] pin_mode = 2'b00;
   logic       pin_pol = 1'b0;
   string      phase = "R1";
   logic [7:0] cur_b  [4][32];
   logic [7:0] prev_b [4][32];

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (phase %s) s=%0d got %b expected %b", tag, phase, s, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // driver: predicts the result of one strobe, pushes it, then applies it
   task automatic strobe_once();
      int         p, k, c, bi, b, slot, bib;
      logic [7:0] byt;
      logic       act;
      item_t      it;
      if (s == 0) begin
         for (int ch = 0; ch < 4; ch++)
            for (int sl = 0; sl < 32; sl++) begin
               prev_b[ch][sl] = cur_b[ch][sl];
               cur_b[ch][sl]  = 8'($urandom);
            end
      end
      p   = (s + 1024 - 32) % 1024;
      k   = p / 32;
      c   = (p % 32) / 8;
      bi  = p % 8;
      byt = (s >= 32) ? cur_b[c][k] : prev_b[c][k];
      it.ser    = (eff_mode == 0) ? 1'b1 : byt[7 - bi];
      it.ser_dc = (dc_left > 0);
      if (dc_left > 0) dc_left--;
      if (eff_mode == 0) it.ser_tag = boot ? "R1" : "R5";
      else it.ser_tag = (p < 32) ? "R4" : "R3";
      case (eff_mode)
         1:       act = (p == 0);
         2:       act = (p >= 1022) || (p <= 1);
         3:       act = (p == 1023) || (p == 0);
         default: act = 1'b0;
      endcase
      it.sync = (eff_mode >= 2 && eff_pol) ? !act : act;
      if (eff_mode == 0)      it.sync_tag = boot ? "R1" : "R5";
      else if (eff_mode == 1) it.sync_tag = "R6";
      else if (eff_pol)       it.sync_tag = "R9";
      else                    it.sync_tag = (eff_mode == 2) ? "R7" : "R8";
      sbq.push_back(it);
      if (p == 1021) begin // R10 capture point
         eff_mode = int'(pin_mode);
         eff_pol  = pin_pol;
         boot     = 0;
      end
      b    = s / 4;
      slot = b / 8;
      bib  = b % 8;
      for (int cc = 0; cc < 4; cc++)
         ch_in[cc] = (garbage && (s % 4 != 0)) ? 1'($urandom) : cur_b[cc][slot][7 - bib];
      fs_in    = (s == 0);
      mode_sel = pin_mode;
      sync_inv = pin_pol;
      bit_en   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bit_en   = 1'b0;
      fs_in    = 1'($urandom);
      mode_sel = 2'($urandom);
      sync_inv = 1'($urandom);
      ch_in    = 4'($urandom);
      @(posedge clk);
      @(negedge clk);
      s = (s + 1) % 1024;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) strobe_once();
   endtask

   task automatic run_to(input int target);
      while (s != target) strobe_once();
   endtask

   always @(posedge clk) took <= bit_en;

   // monitor: pops one prediction per strobe, checks stillness otherwise
   always @(negedge clk) begin
      if (mon_on) begin
         if (took) begin
            if (sbq.size() == 0) begin
               check(1'b1, 1'b0, "R3");
            end else begin
               item_t it;
               it = sbq.pop_front();
               if (!it.ser_dc) check(ser_out, it.ser, it.ser_tag);
               check(sync_out, it.sync, it.sync_tag);
            end
         end else begin
            check(ser_out, last_ser, "R11");
            check(sync_out, last_sync, "R11");
         end
         last_ser  = ser_out;
         last_sync = sync_out;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: run got %0d strobes of frame, expected completion", s);
      finish_run();
   end

   initial begin
      for (int ch = 0; ch < 4; ch++)
         for (int sl = 0; sl < 32; sl++) cur_b[ch][sl] = 8'hFF;
      rst_n    = 1'b0;
      bit_en   = 1'b0;
      fs_in    = 1'b0;
      ch_in    = 4'h0;
      mode_sel = 2'b00;
      sync_inv = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(ser_out, 1'b1, "R1");
      check(sync_out, 1'b0, "R1");
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(ser_out, 1'b1, "R1");
         check(sync_out, 1'b0, "R1");
      end
      last_ser  = ser_out;
      last_sync = sync_out;
      mon_on    = 1;

      phase = "R6"; pin_mode = 2'b01; pin_pol = 1'b0; run(2048);
      phase = "R6"; pin_pol = 1'b1; run(1024);
      phase = "R7"; pin_mode = 2'b10; pin_pol = 1'b0; run(1024);
      phase = "R9"; pin_pol = 1'b1; run(1024);
      phase = "R8"; pin_mode = 2'b11; pin_pol = 1'b0; run(1024);
      phase = "R9"; pin_pol = 1'b1; run(1024);
      phase = "R5"; pin_mode = 2'b00; pin_pol = 1'b1; run(1024);
      phase = "R2"; pin_mode = 2'b01; pin_pol = 1'b0; garbage = 1; run(2048);
      garbage = 0;
      // R10: pins move mid-frame; only the value at position 1021 counts
      phase = "R10";
      run_to(500);
      pin_mode = 2'b10; pin_pol = 1'b1;
      run_to(900);
      pin_mode = 2'b11; pin_pol = 1'b0;
      run_to(40);
      pin_mode = 2'b01;
      run(1100);
      // R12: frame restart in mid-frame
      phase = "R12";
      pin_mode = 2'b10; pin_pol = 1'b0;
      run_to(400);
      s = 0;
      dc_left = 32;
      run(2048);
      @(negedge clk);
      @(negedge clk);
      if (sbq.size() != 0) check(1'b0, 1'b1, "R3");
      finish_run();
   end

endmodule